// File: doc/BRIEF.md
# NAND Flash Command-Address Sequencer

This block runs one command transaction on a large-page NAND flash device. It takes a single request: an operation, an optional column, an optional page address, a large-device flag, a 16-bit-bus flag and a flag saying whether the ready/busy line can be trusted. From these it produces the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins, together with the 8-bit output bus. It picks the address cycles, adds the second command cycle where the operation needs one, and then either waits on the device or polls its status.

Four operations are supported. A page read sends the first read command, the address bytes and the read-start command, then waits for the device. A spare-area read is turned into a page read whose column is moved past the page data. A device reset either waits on ready/busy or, when that line cannot be used, polls status bytes. A random-data-out request repositions the column inside a page that is already loaded.

Between transactions, the host fetches page or status bytes one at a time through a byte-read port. Each byte read costs one read-strobe pulse.

Top module: `nand_cmd_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, chip enable, write strobe and read strobe are all high (inactive), the command-latch and address-latch pins are low, and busy, done and rd_valid are low.
- R2: A page read (op code 0) produces this sequence, with one byte latched on each rising edge of write strobe: a command-latch cycle carrying 0x00, then the address cycles, then a command-latch cycle carrying 0x30. The command-latch and address-latch pins are never high together.
- R3: When a column is supplied, it takes two address-latch cycles, bits 7:0 first and then bits 15:8. A supplied page address takes two cycles (bits 7:0, then bits 15:8), plus a third cycle (bits 23:16) only when the large-device flag is set. A field that is not supplied gets no cycles, and the output bus holds its value at every rising edge of write strobe.
- R4: When the 16-bit-bus flag is set, the column is shifted right by one before it is sent.
- R5: A spare-area read (op code 1) always sends a column, equal to the requested column plus PAGE_BYTES (default 2048), with the R4 shift applied after the addition. It uses the same 0x00 and 0x30 commands as a page read.
- R6: After the read-start command, done is not raised until at least TWB_CYCLES (default 25) clock cycles after that write-strobe rising edge. Done is also not raised before ready/busy has been seen high.
- R7: A reset (op code 2) with the ready/busy-usable flag low sends 0xFF, then the status command 0x70, then reads status bytes one read-strobe pulse at a time. It stops after the first byte whose bit 6 is set; the other bits of that byte are ignored.
- R8: A reset with the ready/busy-usable flag high sends only 0xFF, performs no status reads, and finishes after the R6 wait and once ready is seen.
- R9: A random-data-out request (op code 3) sends 0x05, then its address cycles, then 0xE0. It raises done without waiting on ready/busy, even when that line stays low.
- R10: Every write-strobe low pulse lasts exactly WE_LO cycles (default 3) and every read-strobe low pulse lasts exactly RE_LO cycles (default 3). The two strobes are never low at the same time.
- R11: When the block is idle, a byte-read request produces one read-strobe pulse. rd_data then shows the bus value the device drove during that pulse, and rd_valid is high for exactly one cycle.
- R12: Busy goes high in the cycle after a request is accepted and stays high until the one-cycle done pulse, which coincides with busy going low. Chip enable is low whenever busy is high. Requests that arrive while busy is high have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_op | input | 2 | 0 page read, 1 spare read, 2 reset, 3 random data out |
| req_col_vld | input | 1 | Column field present |
| req_col | input | 16 | Column in bytes |
| req_row_vld | input | 1 | Page address field present |
| req_row | input | 24 | Page (row) address |
| req_big | input | 1 | Device larger than 128 MiB (third row cycle) |
| req_bus16 | input | 1 | Device has a 16-bit data bus |
| req_rb_ok | input | 1 | Ready/busy line can be used |
| rd_req | input | 1 | Fetch one byte from the device |
| rd_data | output | 8 | Last captured byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus value driven to the device |
| nf_dq_i | input | 8 | Bus value returned by the device |
| nf_rb | input | 1 | Ready/busy from the device, high when ready |

## Verification
The hardest case to reach from the ports is telling the two waits after a read-start command apart: the fixed tWB window and the ready/busy poll. The bench device model pulls ready/busy low when it sees 0x30 or 0xFF, and it does so once for a long busy period and once for a period shorter than tWB. Only the short case shows that the fixed window holds done back by itself. A separate override keeps ready/busy low during a random-data-out request, which shows that the request finishes without waiting on the device. The status poll is checked by returning not-ready bytes with every other bit set several times before the byte with bit 6 set. The number of read-strobe pulses must then match exactly.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;

  typedef enum logic [1:0] {
    OP_PAGE_READ  = 2'd0,
    OP_SPARE_READ = 2'd1,
    OP_RESET      = 2'd2,
    OP_RAND_OUT   = 2'd3
  } nf_op_e;

  localparam logic [7:0] NF_CMD_READ      = 8'h00;
  localparam logic [7:0] NF_CMD_READ_GO   = 8'h30;
  localparam logic [7:0] NF_CMD_RAND      = 8'h05;
  localparam logic [7:0] NF_CMD_RAND_GO   = 8'hE0;
  localparam logic [7:0] NF_CMD_STATUS    = 8'h70;
  localparam logic [7:0] NF_CMD_RESET     = 8'hFF;
  localparam int         NF_STAT_RDY_BIT  = 6;

  localparam int NF_COL_BYTES = 2;
  localparam int NF_ROW_BYTES = 3;
  localparam int NF_MAX_ADDR  = NF_COL_BYTES + NF_ROW_BYTES;
  localparam int NF_AIDX_W    = $clog2(NF_MAX_ADDR + 1);

endpackage

// File: rtl/nfseq_sync.sv
module nfseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nfseq_addr_plan.sv
module nfseq_addr_plan
  import nfseq_pkg::*;
#(
  parameter int PAGE_BYTES = 2048
) (
  input  nf_op_e                        op_i,
  input  logic                          col_vld_i,
  input  logic [15:0]                   col_i,
  input  logic                          row_vld_i,
  input  logic [23:0]                   row_i,
  input  logic                          big_i,
  input  logic                          bus16_i,
  output logic [7:0]                    cmd1_o,
  output logic [7:0]                    cmd2_o,
  output logic [NF_AIDX_W-1:0]          n_addr_o,
  output logic [NF_MAX_ADDR-1:0][7:0]   addr_o
);
  localparam logic [15:0] COL_OFF = 16'(PAGE_BYTES);

  logic                  col_p, row_p;
  logic [15:0]           col_sum, col_eff;
  logic [NF_AIDX_W-1:0]  n_col, n_row;
  logic [NF_COL_BYTES-1:0][7:0] cb;
  logic [NF_ROW_BYTES-1:0][7:0] rb;

  always_comb begin
    col_p   = (col_vld_i || op_i == OP_SPARE_READ) && op_i != OP_RESET;
    row_p   = row_vld_i && op_i != OP_RESET;
    col_sum = (op_i == OP_SPARE_READ) ? col_i + COL_OFF : col_i;
    col_eff = bus16_i ? {1'b0, col_sum[15:1]} : col_sum;
    n_col   = col_p ? NF_AIDX_W'(NF_COL_BYTES) : '0;
    n_row   = !row_p ? '0 : (big_i ? NF_AIDX_W'(3) : NF_AIDX_W'(2));
    n_addr_o = n_col + n_row;
    cb[0] = col_eff[7:0];
    cb[1] = col_eff[15:8];
    rb[0] = row_i[7:0];
    rb[1] = row_i[15:8];
    rb[2] = row_i[23:16];
  end

  always_comb begin
    case (op_i)
      OP_RESET:    begin cmd1_o = NF_CMD_RESET; cmd2_o = 8'h00;          end
      OP_RAND_OUT: begin cmd1_o = NF_CMD_RAND;  cmd2_o = NF_CMD_RAND_GO; end
      default:     begin cmd1_o = NF_CMD_READ;  cmd2_o = NF_CMD_READ_GO; end
    endcase
  end

  for (genvar k = 0; k < NF_MAX_ADDR; k++) begin : g_slot
    localparam bit HAS_C   = (k < NF_COL_BYTES);
    localparam int KC      = HAS_C ? k : 0;
    localparam bit HAS_RA  = (k >= NF_COL_BYTES) && (k - NF_COL_BYTES < NF_ROW_BYTES);
    localparam int KRA     = HAS_RA ? k - NF_COL_BYTES : 0;
    localparam bit HAS_R   = (k < NF_ROW_BYTES);
    localparam int KR      = HAS_R ? k : 0;
    assign addr_o[k] = col_p ? (HAS_C ? cb[KC] : (HAS_RA ? rb[KRA] : 8'h00))
                             : (HAS_R ? rb[KR] : 8'h00);
  end
endmodule

// File: rtl/nfseq_strobe.sv
module nfseq_strobe #(
  parameter int WE_LO = 3,
  parameter int WE_HI = 2,
  parameter int RE_LO = 3,
  parameter int RE_HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr_i,
  input  logic       start_rd_i,
  input  logic [7:0] dq_i,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic       fin_o,
  output logic [7:0] byte_o
);
  localparam int M1   = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int M2   = (RE_LO > RE_HI) ? RE_LO : RE_HI;
  localparam int MAXP = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] WLO = CW'(WE_LO - 1);
  localparam logic [CW-1:0] WHI = CW'(WE_HI - 1);
  localparam logic [CW-1:0] RLO = CW'(RE_LO - 1);
  localparam logic [CW-1:0] RHI = CW'(RE_HI - 1);

  logic          act_q, act_d, low_q, low_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    byte_q;
  logic          cap;

  always_comb begin
    act_d = act_q;
    low_d = low_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (start_wr_i || start_rd_i) begin
      act_d = 1'b1;
      low_d = 1'b1;
      rd_d  = start_rd_i;
      cnt_d = start_rd_i ? RLO : WLO;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        if (low_q) begin
          low_d = 1'b0;
          cnt_d = rd_q ? RHI : WHI;
        end else begin
          act_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign cap   = act_q && low_q && rd_q && (cnt_q == '0);
  assign fin_o = act_q && !low_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      low_q <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      low_q <= low_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   byte_q <= 8'h00;
    else if (cap) byte_q <= dq_i;
  end

  assign we_n_o = !(act_q && low_q && !rd_q);
  assign re_n_o = !(act_q && low_q && rd_q);
  assign byte_o = byte_q;
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nfseq_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int WE_LO      = 3,
  parameter int WE_HI      = 2,
  parameter int RE_LO      = 3,
  parameter int RE_HI      = 2,
  parameter int TWB_CYCLES = 25,
  parameter int RB_SYNC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic        req_col_vld,
  input  logic [15:0] req_col,
  input  logic        req_row_vld,
  input  logic [23:0] req_row,
  input  logic        req_big,
  input  logic        req_bus16,
  input  logic        req_rb_ok,
  input  logic        rd_req,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        busy,
  output logic        done,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_o,
  input  logic [7:0]  nf_dq_i,
  input  logic        nf_rb
);
  localparam int TW = $clog2(TWB_CYCLES + 1);
  localparam logic [TW-1:0] TWB_LOAD = TW'(TWB_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_TWB, S_WRB, S_SCMD, S_SRD, S_DATA
  } st_e;

  st_e                  state_q, state_d;
  nf_op_e               op_q;
  logic                 col_vld_q, row_vld_q, big_q, bus16_q, rb_ok_q;
  logic [15:0]          col_q;
  logic [23:0]          row_q;
  logic                 latch;
  logic [NF_AIDX_W-1:0] idx_q, idx_d;
  logic                 sent_q, sent_d;
  logic [TW-1:0]        twb_q, twb_d;
  logic                 done_q, done_d, rdv_q, rdv_d;
  logic                 go_wr, go_rd, fin, rb_s;
  logic [7:0]           cap_byte, cmd1, cmd2, cur_byte;
  logic [NF_AIDX_W-1:0] n_addr;
  logic [NF_MAX_ADDR-1:0][7:0] addr;
  st_e                  after_addr;

  nfseq_addr_plan #(.PAGE_BYTES(PAGE_BYTES)) u_plan (
    .op_i      (op_q),
    .col_vld_i (col_vld_q),
    .col_i     (col_q),
    .row_vld_i (row_vld_q),
    .row_i     (row_q),
    .big_i     (big_q),
    .bus16_i   (bus16_q),
    .cmd1_o    (cmd1),
    .cmd2_o    (cmd2),
    .n_addr_o  (n_addr),
    .addr_o    (addr)
  );

  nfseq_strobe #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_wr_i (go_wr),
    .start_rd_i (go_rd),
    .dq_i       (nf_dq_i),
    .we_n_o     (nf_we_n),
    .re_n_o     (nf_re_n),
    .fin_o      (fin),
    .byte_o     (cap_byte)
  );

  nfseq_sync #(.STAGES(RB_SYNC)) u_rb_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (nf_rb),
    .q_o   (rb_s)
  );

  // where the flow goes once the first command and its address bytes are out
  always_comb begin
    if (op_q == OP_RESET) after_addr = rb_ok_q ? S_TWB : S_SCMD;
    else                  after_addr = S_CMD2;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sent_d  = sent_q;
    twb_d   = twb_q;
    done_d  = 1'b0;
    rdv_d   = 1'b0;
    go_wr   = 1'b0;
    go_rd   = 1'b0;
    latch   = 1'b0;
    case (state_q)
      S_IDLE: begin
        sent_d = 1'b0;
        if (req_valid) begin
          latch   = 1'b1;
          state_d = S_CMD1;
        end else if (rd_req) begin
          state_d = S_DATA;
        end
      end
      S_CMD1, S_ADDR, S_CMD2, S_SCMD: begin
        if (!sent_q) begin
          go_wr  = 1'b1;
          sent_d = 1'b1;
        end else if (fin) begin
          sent_d = 1'b0;
          case (state_q)
            S_CMD1: begin
              idx_d = '0;
              if (n_addr != '0) state_d = S_ADDR;
              else begin
                state_d = after_addr;
                twb_d   = TWB_LOAD;
              end
            end
            S_ADDR: begin
              if (idx_q == n_addr - 1'b1) begin
                state_d = after_addr;
                twb_d   = TWB_LOAD;
              end else begin
                idx_d = idx_q + 1'b1;
              end
            end
            S_CMD2: begin
              if (op_q == OP_RAND_OUT) begin
                state_d = S_IDLE;
                done_d  = 1'b1;
              end else begin
                state_d = S_TWB;
                twb_d   = TWB_LOAD;
              end
            end
            default: state_d = S_SRD;
          endcase
        end
      end
      S_TWB: begin
        if (twb_q == '0) state_d = S_WRB;
        else             twb_d   = twb_q - 1'b1;
      end
      S_WRB: begin
        if (rb_s) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_SRD: begin
        if (!sent_q) begin
          go_rd  = 1'b1;
          sent_d = 1'b1;
        end else if (fin) begin
          sent_d = 1'b0;
          if (cap_byte[NF_STAT_RDY_BIT]) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      S_DATA: begin
        if (!sent_q) begin
          go_rd  = 1'b1;
          sent_d = 1'b1;
        end else if (fin) begin
          sent_d  = 1'b0;
          state_d = S_IDLE;
          rdv_d   = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      sent_q  <= 1'b0;
      twb_q   <= '0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sent_q  <= sent_d;
      twb_q   <= twb_d;
      done_q  <= done_d;
      rdv_q   <= rdv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_PAGE_READ;
      col_vld_q <= 1'b0;
      col_q     <= '0;
      row_vld_q <= 1'b0;
      row_q     <= '0;
      big_q     <= 1'b0;
      bus16_q   <= 1'b0;
      rb_ok_q   <= 1'b0;
    end else if (latch) begin
      op_q      <= nf_op_e'(req_op);
      col_vld_q <= req_col_vld;
      col_q     <= req_col;
      row_vld_q <= req_row_vld;
      row_q     <= req_row;
      big_q     <= req_big;
      bus16_q   <= req_bus16;
      rb_ok_q   <= req_rb_ok;
    end
  end

  always_comb begin
    case (state_q)
      S_CMD1:  cur_byte = cmd1;
      S_ADDR:  cur_byte = addr[idx_q];
      S_CMD2:  cur_byte = cmd2;
      S_SCMD:  cur_byte = NF_CMD_STATUS;
      default: cur_byte = 8'h00;
    endcase
  end

  assign nf_cle   = (state_q == S_CMD1) || (state_q == S_CMD2) || (state_q == S_SCMD);
  assign nf_ale   = (state_q == S_ADDR);
  assign nf_dq_o  = cur_byte;
  assign busy     = (state_q != S_IDLE) && (state_q != S_DATA);
  assign nf_ce_n  = (state_q == S_IDLE);
  assign done     = done_q;
  assign rd_valid = rdv_q;
  assign rd_data  = cap_byte;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int WE_LO = 3,
  parameter int RE_LO = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic [7:0] nf_dq_o,
  input logic       busy,
  input logic       done,
  input logic       rd_valid
);
  logic [7:0] we_lo_cnt, re_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= 8'd0;
      re_lo_cnt <= 8'd0;
    end else begin
      we_lo_cnt <= nf_we_n ? 8'd0 : we_lo_cnt + 8'd1;
      re_lo_cnt <= nf_re_n ? 8'd0 : re_lo_cnt + 8'd1;
    end
  end

  p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  p_dq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> $stable(nf_dq_o));

  p_we_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> we_lo_cnt == 8'(WE_LO));

  p_re_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_re_n) |-> re_lo_cnt == 8'(RE_LO));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nf_we_n || nf_re_n);

  p_rdv_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_ce_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !nf_ce_n);

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.WE_LO(WE_LO), .RE_LO(RE_LO)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nf_ce_n  (nf_ce_n),
  .nf_cle   (nf_cle),
  .nf_ale   (nf_ale),
  .nf_we_n  (nf_we_n),
  .nf_re_n  (nf_re_n),
  .nf_dq_o  (nf_dq_o),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid)
);

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
  localparam int TWB = 25;
  localparam int PAGE = 2048;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_col_vld, req_row_vld, req_big, req_bus16, req_rb_ok, rd_req;
  logic [1:0]  req_op;
  logic [15:0] req_col;
  logic [23:0] req_row;
  logic [7:0]  rd_data, nf_dq_o, nf_dq_i;
  logic        rd_valid, busy, done, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_rb;

  always #2 clk = ~clk;

  nand_cmd_seq u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_col_vld(req_col_vld), .req_col(req_col), .req_row_vld(req_row_vld),
    .req_row(req_row), .req_big(req_big), .req_bus16(req_bus16), .req_rb_ok(req_rb_ok),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  int total = 0, failed = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      summary();
    end
  end

  // ---------------- device model ----------------
  logic [9:0] log_q [0:15];
  int  log_n = 0, re_falls = 0, last_cmd_cyc = 0, rb_rise_cyc = 0, busy_len = 40;
  int  stat_cnt = 0, stat_busy = 3, data_idx = 0;
  bit  stat_mode = 0, pull_en = 1;
  logic rb_model = 1'b1, hold_busy = 1'b0;

  assign nf_rb = rb_model & ~hold_busy;

  always @(posedge nf_we_n) begin
    if (rst_n === 1'b1) begin
      if (log_n < 16) log_q[log_n] = {nf_cle, nf_ale, nf_dq_o};
      log_n++;
      if (nf_cle) begin
        last_cmd_cyc = cyc;
        stat_mode = (nf_dq_o == 8'h70);
        stat_cnt = 0;
        if (nf_dq_o == 8'h30) data_idx = 0;
      end
    end
  end

  always @(posedge nf_we_n) begin
    if (rst_n === 1'b1 && nf_cle && (nf_dq_o == 8'h30 || nf_dq_o == 8'hFF) && pull_en) begin
      rb_model = 1'b0;
      repeat (busy_len) @(posedge clk);
      #1 rb_model = 1'b1;
      rb_rise_cyc = cyc;
    end
  end

  always @(negedge nf_re_n) begin
    if (rst_n === 1'b1) begin
      re_falls++;
      if (stat_mode) begin
        nf_dq_i = (stat_cnt < stat_busy) ? 8'hBF : 8'h40;
        stat_cnt++;
      end else begin
        nf_dq_i = 8'hA0 + 8'(data_idx);
        data_idx++;
      end
    end
  end

  // ---------------- stimulus table ----------------
  typedef struct packed {
    logic [1:0]  op;
    logic        cv;
    logic [15:0] col;
    logic        rv;
    logic [23:0] row;
    logic        big;
    logic        b16;
    logic [2:0]  naddr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 16'h0123, 1'b1, 24'h0A0B0C, 1'b0, 1'b0, 3'd4},
    '{2'd0, 1'b1, 16'h0123, 1'b1, 24'h0A0B0C, 1'b1, 1'b0, 3'd5},
    '{2'd0, 1'b1, 16'h0246, 1'b1, 24'h112233, 1'b1, 1'b1, 3'd5},
    '{2'd1, 1'b1, 16'h0010, 1'b1, 24'h000123, 1'b0, 1'b0, 3'd4},
    '{2'd1, 1'b0, 16'h0010, 1'b1, 24'h000123, 1'b0, 1'b1, 3'd4},
    '{2'd0, 1'b0, 16'hFFFF, 1'b1, 24'h00BEEF, 1'b0, 1'b0, 3'd2},
    '{2'd0, 1'b1, 16'h0777, 1'b0, 24'hFFFFFF, 1'b1, 1'b0, 3'd2},
    '{2'd3, 1'b1, 16'h0555, 1'b0, 24'h000000, 1'b0, 1'b0, 3'd2}
  };

  logic [9:0] exp_q [0:15];
  int exp_n;

  task automatic build_exp(input vec_t v);
    logic [15:0] c;
    bit colp;
    exp_n = 0;
    exp_q[exp_n++] = {2'b10, (v.op == 2'd3) ? 8'h05 : 8'h00};
    colp = v.cv || v.op == 2'd1;
    c = v.col + ((v.op == 2'd1) ? 16'(PAGE) : 16'd0);
    if (v.b16) c = c >> 1;
    if (colp) begin
      exp_q[exp_n++] = {2'b01, c[7:0]};
      exp_q[exp_n++] = {2'b01, c[15:8]};
    end
    if (v.rv) begin
      exp_q[exp_n++] = {2'b01, v.row[7:0]};
      exp_q[exp_n++] = {2'b01, v.row[15:8]};
      if (v.big) exp_q[exp_n++] = {2'b01, v.row[23:16]};
    end
    exp_q[exp_n++] = {2'b10, (v.op == 2'd3) ? 8'hE0 : 8'h30};
  endtask

  task automatic send_req(input logic [1:0] op, input logic cv, input logic [15:0] col,
                          input logic rv, input logic [23:0] row, input logic big,
                          input logic b16, input logic rbok);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_col_vld = cv; req_col = col;
    req_row_vld = rv; req_row = row; req_big = big; req_bus16 = b16; req_rb_ok = rbok;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  int done_cyc;
  task automatic wait_done(input string rq, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin ok = 1; done_cyc = cyc; break; end
      @(negedge clk);
    end
    chk(ok, rq, "done arrives", 32'(ok), 32'd1);
  endtask

  task automatic cmp_log(input string rq);
    bit ok;
    int bad;
    ok = (log_n == exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < 16; i++)
      if (ok && log_q[i] !== exp_q[i]) begin ok = 0; bad = i; end
    if (bad >= 0) chk(ok, rq, $sformatf("byte %0d {cle,ale,dq}", bad), 32'(log_q[bad]), 32'(exp_q[bad]));
    else          chk(ok, rq, "cycle count", 32'(log_n), 32'(exp_n));
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.op == 2'd3) return "R9";
    if (v.op == 2'd1) return "R5";
    if (v.b16)        return "R4";
    return "R3";
  endfunction

  initial begin
    bit ok;
    int nale;
    rst_n = 1'b0; req_valid = 1'b0; rd_req = 1'b0; nf_dq_i = 8'h00;
    req_op = 2'd0; req_col_vld = 0; req_col = '0; req_row_vld = 0; req_row = '0;
    req_big = 0; req_bus16 = 0; req_rb_ok = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nf_ce_n && nf_we_n && nf_re_n, "R1", "strobes/CE high in reset",
        {nf_ce_n, nf_we_n, nf_re_n}, 3'b111);
    chk(!nf_cle && !nf_ale && !busy && !done && !rd_valid, "R1", "latches/flags low in reset",
        {nf_cle, nf_ale, busy, done, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nf_ce_n && !busy && nf_we_n, "R1", "idle after release", {nf_ce_n, busy, nf_we_n}, 3'b101);

    // table of transactions (R2..R5, R9)
    for (int v = 0; v < NV; v++) begin
      log_n = 0;
      build_exp(VECS[v]);
      send_req(VECS[v].op, VECS[v].cv, VECS[v].col, VECS[v].rv, VECS[v].row,
               VECS[v].big, VECS[v].b16, 1'b1);
      chk(busy === 1'b1, "R12", "busy after accept", 32'(busy), 1);
      wait_done("R2", ok);
      cmp_log(tag_of(VECS[v]));
      nale = 0;
      for (int i = 0; i < log_n && i < 16; i++) if (log_q[i][8]) nale++;
      chk(nale == VECS[v].naddr, "R3", "address cycle count", 32'(nale), 32'(VECS[v].naddr));
      @(negedge clk);
      chk(!done && !busy, "R12", "done is one cycle", {done, busy}, 0);
      repeat (4) @(negedge clk);
    end

    // R6: long device busy -> ready dominates
    busy_len = 60; log_n = 0;
    send_req(2'd0, 1, 16'h0, 1, 24'h1, 0, 0, 1);
    wait_done("R6", ok);
    chk(done_cyc > rb_rise_cyc, "R6", "done after ready rise", done_cyc, rb_rise_cyc);
    // R6: short device busy -> tWB window dominates
    busy_len = 2;
    send_req(2'd0, 1, 16'h0, 1, 24'h2, 0, 0, 1);
    wait_done("R6", ok);
    chk(done_cyc - last_cmd_cyc >= TWB, "R6", "tWB window held", done_cyc - last_cmd_cyc, TWB);

    // R11: byte reads after the page read
    for (int b = 0; b < 3; b++) begin
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      ok = 0;
      for (int i = 0; i < 100; i++) begin
        if (rd_valid) begin ok = 1; break; end
        @(negedge clk);
      end
      chk(ok && rd_data == 8'hA0 + 8'(b), "R11", "data byte", rd_data, 8'hA0 + 8'(b));
    end

    // R7: reset with status polling
    busy_len = 40; pull_en = 0; log_n = 0; re_falls = 0; stat_busy = 3;
    send_req(2'd2, 1, 16'h1234, 1, 24'h5, 1, 0, 0);
    wait_done("R7", ok);
    chk(log_n == 2 && log_q[0] == {2'b10, 8'hFF} && log_q[1] == {2'b10, 8'h70},
        "R7", "reset then status command", {log_q[0], log_q[1]}, {10'h2FF, 10'h270});
    chk(re_falls == 4, "R7", "status reads until bit 6", re_falls, 4);

    // R8: reset with ready/busy line
    pull_en = 1; log_n = 0; re_falls = 0;
    send_req(2'd2, 0, 16'h0, 0, 24'h0, 0, 0, 1);
    wait_done("R8", ok);
    chk(log_n == 1 && log_q[0] == {2'b10, 8'hFF}, "R8", "only reset command", log_n, 1);
    chk(re_falls == 0 && done_cyc > rb_rise_cyc, "R8", "no status reads, waits ready",
        re_falls, 0);

    // R9: random data out ignores a stuck-busy device
    hold_busy = 1'b1; log_n = 0;
    send_req(2'd3, 1, 16'h0042, 0, 24'h0, 0, 0, 1);
    wait_done("R9", ok);
    chk(log_n == 4 && log_q[3] == {2'b10, 8'hE0}, "R9", "start command last", log_q[3], 10'h2E0);
    hold_busy = 1'b0;

    // R12: request during a transaction is ignored
    log_n = 0;
    build_exp(VECS[0]);
    send_req(VECS[0].op, VECS[0].cv, VECS[0].col, VECS[0].rv, VECS[0].row, 0, 0, 1);
    repeat (6) @(negedge clk);
    send_req(2'd2, 0, 16'h0, 0, 24'h0, 0, 0, 0);
    wait_done("R12", ok);
    cmp_log("R12");
    repeat (60) @(negedge clk);
    chk(log_n == exp_n && !busy, "R12", "no late transaction", log_n, exp_n);

    summary();
  end
endmodule